// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This unit holds the two W-bit result registers (HI and LO) that sit beside the integer datapath of a simple RISC core. It runs signed and unsigned multiplies, multiply-accumulate and multiply-subtract on the 2W-bit pair {HI,LO}, a multiply whose low half is returned directly, signed and unsigned division, and moves between the operands and HI or LO.

An operation is requested by pulsing `start_i` for one cycle, with a class bit, a 6-bit function code and two operands. Multiplies, accumulates and moves finish in one cycle. Division is an iterative restoring divider that keeps `busy_o` high for W cycles. A request to read HI or LO that arrives during a division is held. It is answered in the cycle the quotient and remainder are written, and it returns the new value.

Top module: `hilo_mdu`

## Requirements
- R1: After reset, HI and LO are zero, `busy_o` is 0 and `rvalid_o` is 0.
- R2: With `cls_i`=0, code 0x18 (signed) or 0x19 (unsigned) forms the 2W-bit product of `a_i` and `b_i`. The upper W bits go to HI and the lower W bits to LO at the next clock edge, and `busy_o` stays 0.
- R3: With `cls_i`=0, code 0x1A (signed) or 0x1B (unsigned) with a nonzero divisor writes the quotient to LO and the remainder to HI. Signed division truncates toward zero and the remainder takes the dividend's sign. The most negative value divided by -1 gives the most negative value as quotient and 0 as remainder.
- R4: A division raises `busy_o` in the cycle after the start. It keeps `busy_o` high for exactly W cycles and writes HI and LO at the edge where `busy_o` falls.
- R5: Division by zero, signed or unsigned, completes with the normal latency and leaves LO all ones and HI equal to the dividend.
- R6: With `cls_i`=0, code 0x10 returns HI and code 0x12 returns LO on `rdata_o`, with `rvalid_o` high for one cycle after the start edge. Code 0x11 loads HI and code 0x13 loads LO from `a_i`.
- R7: With `cls_i`=1, codes 0x00 (signed) and 0x01 (unsigned) add the product to {HI,LO}, and codes 0x04 (signed) and 0x05 (unsigned) subtract it. The arithmetic is modulo 2^(2W), with HI as the upper half.
- R8: With `cls_i`=1, code 0x02 returns the low W bits of the signed product on `rdata_o` with `rvalid_o`, and leaves HI and LO unchanged.
- R9: A read of HI or LO started while `busy_o` is high produces no response until the division completes. It is answered at the completion edge with the newly written value, and `rvalid_o` is never high while `busy_o` is high.
- R10: Any start other than a read while `busy_o` is high is ignored. A start with an unassigned code changes neither HI nor LO and gives no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle operation request |
| cls_i | input | 1 | Code class: 0 primary, 1 accumulate/32-bit multiply |
| fn_i | input | 6 | Function code within the class |
| a_i | input | W | First operand (dividend, source of moves) |
| b_i | input | W | Second operand (divisor) |
| busy_o | output | 1 | Division in progress |
| rdata_o | output | W | Read or direct-multiply result |
| rvalid_o | output | 1 | `rdata_o` holds a fresh result this cycle |

## Verification
The bench builds the unit with W=4. Every pair of 4-bit operands then fits in a sweep of 256 cases. Signed and unsigned multiply, all four accumulate codes, the direct multiply and both divide modes are each checked against every operand pair, which takes in the zero divisor, the most-negative-by-minus-one overflow and all sign combinations of the remainder. Directed sequences cover a read held during a division and a write dropped during one.

// File: rtl/hilo_mdu_pkg.sv
package hilo_mdu_pkg;

   // primary class codes (cls_i = 0)
   localparam logic [5:0] FN_RD_HI  = 6'h10;
   localparam logic [5:0] FN_WR_HI  = 6'h11;
   localparam logic [5:0] FN_RD_LO  = 6'h12;
   localparam logic [5:0] FN_WR_LO  = 6'h13;
   localparam logic [5:0] FN_MUL_S  = 6'h18;
   localparam logic [5:0] FN_MUL_U  = 6'h19;
   localparam logic [5:0] FN_DIV_S  = 6'h1A;
   localparam logic [5:0] FN_DIV_U  = 6'h1B;
   // secondary class codes (cls_i = 1)
   localparam logic [5:0] FN_MAC_S  = 6'h00;
   localparam logic [5:0] FN_MAC_U  = 6'h01;
   localparam logic [5:0] FN_MUL32  = 6'h02;
   localparam logic [5:0] FN_MSB_S  = 6'h04;
   localparam logic [5:0] FN_MSB_U  = 6'h05;

   typedef enum logic [3:0] {
      OP_NONE,
      OP_MUL,
      OP_DIV,
      OP_ACC_ADD,
      OP_ACC_SUB,
      OP_MUL32,
      OP_RD_HI,
      OP_RD_LO,
      OP_WR_HI,
      OP_WR_LO
   } op_e;

   typedef struct packed {
      op_e  op;
      logic sgn;
   } dec_t;

endpackage

// File: rtl/hilo_mdu_decode.sv
module hilo_mdu_decode
   import hilo_mdu_pkg::*;
(
   input  logic       cls_i,
   input  logic [5:0] fn_i,
   output dec_t       dec_o
);

   always_comb begin
      dec_o.op  = OP_NONE;
      dec_o.sgn = 1'b0;
      if (!cls_i) begin
         unique case (fn_i)
            FN_RD_HI: dec_o.op = OP_RD_HI;
            FN_WR_HI: dec_o.op = OP_WR_HI;
            FN_RD_LO: dec_o.op = OP_RD_LO;
            FN_WR_LO: dec_o.op = OP_WR_LO;
            FN_MUL_S: begin dec_o.op = OP_MUL; dec_o.sgn = 1'b1; end
            FN_MUL_U: dec_o.op = OP_MUL;
            FN_DIV_S: begin dec_o.op = OP_DIV; dec_o.sgn = 1'b1; end
            FN_DIV_U: dec_o.op = OP_DIV;
            default:  dec_o.op = OP_NONE;
         endcase
      end else begin
         unique case (fn_i)
            FN_MAC_S: begin dec_o.op = OP_ACC_ADD; dec_o.sgn = 1'b1; end
            FN_MAC_U: dec_o.op = OP_ACC_ADD;
            FN_MUL32: begin dec_o.op = OP_MUL32; dec_o.sgn = 1'b1; end
            FN_MSB_S: begin dec_o.op = OP_ACC_SUB; dec_o.sgn = 1'b1; end
            FN_MSB_U: dec_o.op = OP_ACC_SUB;
            default:  dec_o.op = OP_NONE;
         endcase
      end
   end

endmodule

// File: rtl/hilo_mdu_mult.sv
module hilo_mdu_mult #(
   parameter int W = 32
) (
   input  logic [W-1:0]   a_i,
   input  logic [W-1:0]   b_i,
   input  logic           sgn_i,
   output logic [2*W-1:0] prod_o
);

   localparam int PW = 2 * W;

   logic [PW-1:0] ext_a;
   logic [PW-1:0] ext_b;

   // sign- or zero-extend to full width; a 2W-bit product of the
   // extended operands is exact modulo 2^(2W) in both modes
   assign ext_a  = {{W{sgn_i & a_i[W-1]}}, a_i};
   assign ext_b  = {{W{sgn_i & b_i[W-1]}}, b_i};
   assign prod_o = ext_a * ext_b;

endmodule

// File: rtl/hilo_mdu_div.sv
module hilo_mdu_div #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic         sgn_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic         busy_o,
   output logic         done_o,
   output logic [W-1:0] quo_o,
   output logic [W-1:0] rem_o
);

   localparam int CW = (W > 2) ? $clog2(W) : 1;
   localparam logic [CW-1:0] CNT_LAST = CW'(W - 1);

   logic [W-1:0]  rem_q, quo_q, dvs_q;
   logic [CW-1:0] cnt_q;
   logic          busy_q, negq_q, negr_q, dz_q;

   logic [W-1:0]  mag_a, mag_b;
   logic [W:0]    trial, diff;
   logic          fits;
   logic [W-1:0]  rem_n, quo_n;

   assign mag_a = (sgn_i & a_i[W-1]) ? (~a_i + 1'b1) : a_i;
   assign mag_b = (sgn_i & b_i[W-1]) ? (~b_i + 1'b1) : b_i;

   // one restoring step: shift in next dividend bit, try subtract
   assign trial = {rem_q, quo_q[W-1]};
   assign diff  = trial - {1'b0, dvs_q};
   assign fits  = ~diff[W];
   assign rem_n = fits ? diff[W-1:0] : trial[W-1:0];
   assign quo_n = {quo_q[W-2:0], fits};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q  <= '0;
         quo_q  <= '0;
         dvs_q  <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         negq_q <= 1'b0;
         negr_q <= 1'b0;
         dz_q   <= 1'b0;
      end else if (load_i && !busy_q) begin
         rem_q  <= '0;
         quo_q  <= mag_a;
         dvs_q  <= mag_b;
         cnt_q  <= CNT_LAST;
         busy_q <= 1'b1;
         negq_q <= sgn_i & (a_i[W-1] ^ b_i[W-1]);
         negr_q <= sgn_i & a_i[W-1];
         dz_q   <= (b_i == '0);
      end else if (busy_q) begin
         rem_q  <= rem_n;
         quo_q  <= quo_n;
         cnt_q  <= cnt_q - 1'b1;
         if (cnt_q == '0) busy_q <= 1'b0;
      end
   end

   assign busy_o = busy_q;
   assign done_o = busy_q && (cnt_q == '0);
   // zero divisor: quotient stays all ones, no sign fix-up
   assign quo_o  = (negq_q && !dz_q) ? (~quo_n + 1'b1) : quo_n;
   assign rem_o  = negr_q ? (~rem_n + 1'b1) : rem_n;

endmodule

// File: rtl/hilo_mdu.sv
module hilo_mdu
   import hilo_mdu_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic         cls_i,
   input  logic [5:0]   fn_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic         busy_o,
   output logic [W-1:0] rdata_o,
   output logic         rvalid_o
);

   localparam int PW = 2 * W;

   generate
      if (W < 2) begin : g_bad_width
         $error("hilo_mdu: W must be at least 2");
      end
   endgenerate

   dec_t          dec;
   logic [PW-1:0] prod;
   logic [PW-1:0] acc;
   logic [W-1:0]  hi_q, lo_q;
   logic [W-1:0]  dv_quo, dv_rem;
   logic          dv_busy, dv_done;
   logic          pend_q, pend_hi_q;
   logic          is_rd, take, rd_hi_now;

   hilo_mdu_decode u_dec (
      .cls_i (cls_i),
      .fn_i  (fn_i),
      .dec_o (dec)
   );

   hilo_mdu_mult #(.W(W)) u_mul (
      .a_i    (a_i),
      .b_i    (b_i),
      .sgn_i  (dec.sgn),
      .prod_o (prod)
   );

   hilo_mdu_div #(.W(W)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (start_i && dec.op == OP_DIV),
      .sgn_i  (dec.sgn),
      .a_i    (a_i),
      .b_i    (b_i),
      .busy_o (dv_busy),
      .done_o (dv_done),
      .quo_o  (dv_quo),
      .rem_o  (dv_rem)
   );

   assign acc       = {hi_q, lo_q};
   assign is_rd     = (dec.op == OP_RD_HI) || (dec.op == OP_RD_LO);
   assign take      = start_i && !dv_busy;
   assign rd_hi_now = (dec.op == OP_RD_HI);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q      <= '0;
         lo_q      <= '0;
         rdata_o   <= '0;
         rvalid_o  <= 1'b0;
         pend_q    <= 1'b0;
         pend_hi_q <= 1'b0;
      end else begin
         rvalid_o <= 1'b0;
         if (dv_done) begin
            hi_q <= dv_rem;
            lo_q <= dv_quo;
            if (pend_q) begin
               rdata_o  <= pend_hi_q ? dv_rem : dv_quo;
               rvalid_o <= 1'b1;
               pend_q   <= 1'b0;
            end else if (start_i && is_rd) begin
               rdata_o  <= rd_hi_now ? dv_rem : dv_quo;
               rvalid_o <= 1'b1;
            end
         end else if (dv_busy) begin
            if (start_i && is_rd && !pend_q) begin
               pend_q    <= 1'b1;
               pend_hi_q <= rd_hi_now;
            end
         end else if (take) begin
            unique case (dec.op)
               OP_MUL:     {hi_q, lo_q} <= prod;
               OP_ACC_ADD: {hi_q, lo_q} <= acc + prod;
               OP_ACC_SUB: {hi_q, lo_q} <= acc - prod;
               OP_WR_HI:   hi_q <= a_i;
               OP_WR_LO:   lo_q <= a_i;
               OP_RD_HI: begin
                  rdata_o  <= hi_q;
                  rvalid_o <= 1'b1;
               end
               OP_RD_LO: begin
                  rdata_o  <= lo_q;
                  rvalid_o <= 1'b1;
               end
               OP_MUL32: begin
                  rdata_o  <= prod[W-1:0];
                  rvalid_o <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   assign busy_o = dv_busy;

endmodule

// File: rtl/hilo_mdu_chk.sv
module hilo_mdu_chk
   import hilo_mdu_pkg::*;
#(
   parameter int W = 32
) (
   input logic       clk,
   input logic       rst_n,
   input logic       start_i,
   input logic       cls_i,
   input logic [5:0] fn_i,
   input logic       busy_o,
   input logic       rvalid_o
);

   logic [15:0] busy_run;
   logic        div_go, mul_go, rd_go, m32_go;

   always_ff @(posedge clk) begin
      if (!rst_n)      busy_run <= '0;
      else if (busy_o) busy_run <= busy_run + 1'b1;
      else             busy_run <= '0;
   end

   assign div_go = start_i && !cls_i && (fn_i == FN_DIV_S || fn_i == FN_DIV_U);
   assign mul_go = start_i && !cls_i && (fn_i == FN_MUL_S || fn_i == FN_MUL_U);
   assign rd_go  = start_i && !cls_i && (fn_i == FN_RD_HI || fn_i == FN_RD_LO);
   assign m32_go = start_i && cls_i && (fn_i == FN_MUL32);

   AST_DIV_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      div_go && !busy_o |=> busy_o);                                  // R4
   AST_DIV_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> busy_run == 16'(W));                         // R4
   AST_MUL_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mul_go && !busy_o |=> !busy_o);                                 // R2
   AST_READ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      rd_go && !busy_o |=> rvalid_o);                                 // R6
   AST_MUL32_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      m32_go && !busy_o |=> rvalid_o);                                // R8
   AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid_o |-> !busy_o);                                          // R9

endmodule

bind hilo_mdu hilo_mdu_chk #(.W(W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .cls_i    (cls_i),
   .fn_i     (fn_i),
   .busy_o   (busy_o),
   .rvalid_o (rvalid_o)
);

// File: tb/sim_hilo_mdu.sv
module sim_hilo_mdu;

   localparam int W = 4;
   localparam int M = 1 << W;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         cls = 1'b0;
   logic [5:0]   fn = '0;
   logic [W-1:0] a = '0;
   logic [W-1:0] b = '0;
   logic         busy;
   logic [W-1:0] rdata;
   logic         rvalid;

   int checks = 0;
   int errors = 0;
   bit over = 0;

   always #5 clk = ~clk;

   hilo_mdu #(.W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .cls_i(cls), .fn_i(fn),
      .a_i(a), .b_i(b), .busy_o(busy), .rdata_o(rdata), .rvalid_o(rvalid)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int sx(input logic [W-1:0] v);
      return v[W-1] ? int'(v) - M : int'(v);
   endfunction

   // caller is at a negedge; returns at the next negedge
   task automatic issue(input logic c, input logic [5:0] f,
                        input logic [W-1:0] x, input logic [W-1:0] y);
      start = 1'b1; cls = c; fn = f; a = x; b = y;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic rd(input bit hi, output int v, output bit vld);
      issue(1'b0, hi ? 6'h10 : 6'h12, '0, '0);
      v = int'(rdata);
      vld = rvalid;
   endtask

   task automatic wait_div(output int n);
      n = 0;
      while (busy && n < 100) begin
         @(negedge clk);
         n++;
      end
   endtask

   initial begin
      int v, n, e, p, acc;
      bit vld;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(busy == 1'b0, "R1 busy", int'(busy), 0);
      chk(rvalid == 1'b0, "R1 rvalid", int'(rvalid), 0);
      rd(1, v, vld); chk(v == 0 && vld, "R1 HI", v, 0);
      rd(0, v, vld); chk(v == 0 && vld, "R1 LO", v, 0);

      // R2 multiply sweep
      for (int sg = 0; sg < 2; sg++)
         for (int x = 0; x < M; x++)
            for (int y = 0; y < M; y++) begin
               issue(1'b0, sg ? 6'h18 : 6'h19, W'(x), W'(y));
               chk(!busy, "R2 busy", int'(busy), 0);
               p = sg ? sx(W'(x)) * sx(W'(y)) : x * y;
               p = p & (M * M - 1);
               rd(1, v, vld); chk(vld && v == (p >> W), "R2 HI", v, p >> W);
               rd(0, v, vld); chk(vld && v == (p & (M - 1)), "R2 LO", v, p & (M - 1));
            end

      // R7 accumulate sweep (preload via R6 writes)
      for (int k = 0; k < 4; k++)
         for (int x = 0; x < M; x++)
            for (int y = 0; y < M; y++) begin
               int hi0, lo0, code;
               bit sg, sub;
               hi0 = (x ^ y ^ k) & (M - 1);
               lo0 = (x + 3 * y + k) & (M - 1);
               code = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 4 : 5;
               sg = (k == 0 || k == 2);
               sub = (k >= 2);
               issue(1'b0, 6'h11, W'(hi0), '0);
               issue(1'b0, 6'h13, W'(lo0), '0);
               issue(1'b1, 6'(code), W'(x), W'(y));
               p = sg ? sx(W'(x)) * sx(W'(y)) : x * y;
               acc = hi0 * M + lo0;
               e = (sub ? acc - p : acc + p) & (M * M - 1);
               rd(1, v, vld); chk(vld && v == (e >> W), "R7 HI", v, e >> W);
               rd(0, v, vld); chk(vld && v == (e & (M - 1)), "R7 LO", v, e & (M - 1));
            end

      // R8 direct multiply: result returned, HI/LO untouched
      issue(1'b0, 6'h11, W'(5), '0);
      issue(1'b0, 6'h13, W'(9), '0);
      for (int x = 0; x < M; x++)
         for (int y = 0; y < M; y++) begin
            issue(1'b1, 6'h02, W'(x), W'(y));
            e = (sx(W'(x)) * sx(W'(y))) & (M - 1);
            chk(rvalid && int'(rdata) == e, "R8 result", int'(rdata), e);
         end
      rd(1, v, vld); chk(v == 5, "R8 HI kept", v, 5);
      rd(0, v, vld); chk(v == 9, "R8 LO kept", v, 9);

      // R3/R4/R5 divide sweep
      for (int sg = 0; sg < 2; sg++)
         for (int x = 0; x < M; x++)
            for (int y = 0; y < M; y++) begin
               int eq, er;
               issue(1'b0, sg ? 6'h1A : 6'h1B, W'(x), W'(y));
               wait_div(n);
               chk(n == W, "R4 latency", n, W);
               if (y == 0) begin
                  eq = M - 1; er = x;
               end else if (sg) begin
                  eq = (sx(W'(x)) / sx(W'(y))) & (M - 1);
                  er = (sx(W'(x)) % sx(W'(y))) & (M - 1);
               end else begin
                  eq = x / y; er = x % y;
               end
               rd(0, v, vld);
               chk(v == eq, y == 0 ? "R5 LO" : "R3 LO", v, eq);
               rd(1, v, vld);
               chk(v == er, y == 0 ? "R5 HI" : "R3 HI", v, er);
            end

      // R9 held read and R10 write ignored during a divide
      issue(1'b0, 6'h1B, W'(13), W'(4));
      issue(1'b0, 6'h12, '0, '0);
      chk(!rvalid, "R9 no early ack", int'(rvalid), 0);
      issue(1'b0, 6'h11, W'(7), '0);
      issue(1'b0, 6'h18, W'(7), W'(7));
      while (busy) @(negedge clk);
      chk(rvalid && int'(rdata) == 3, "R9 held read", int'(rdata), 3);
      rd(1, v, vld); chk(v == 1, "R10 write dropped", v, 1);
      rd(0, v, vld); chk(v == 3, "R10 mul dropped", v, 3);

      // R10 unassigned codes: no response, no change
      issue(1'b0, 6'h3F, W'(6), W'(6));
      chk(!rvalid, "R10 no ack", int'(rvalid), 0);
      issue(1'b1, 6'h03, W'(6), W'(6));
      chk(!rvalid, "R10 no ack cls1", int'(rvalid), 0);
      rd(1, v, vld); chk(v == 1, "R10 HI", v, 1);
      rd(0, v, vld); chk(v == 3, "R10 LO", v, 3);

      if (!over) begin
         over = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!over) begin
         over = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule